// File: doc/BRIEF.md
# Indirect Coprocessor Register Access Port

This block sits between a processor core and a signal-processing coprocessor. The core cannot address the coprocessor's internal registers directly. It loads an index into a pointer register and then moves data through a single data window. Every read or write through the window advances the pointer by one, so the core can stream a run of consecutive registers without reloading the pointer.

The bank holds sixteen 16-bit registers. Index 0 is the mode control word, and its bit 0 selects the branch metric type. Index 1 holds the traceback length. The other indices are plain storage. A separate command input accepts a 2-bit opcode. The block turns an accepted opcode into a one-cycle pulse on one of four lines: equalize, decode, traceback, or engine reset. A busy flag covers the time the engine spends on a running operation.

Top module: `copro_regport`

## Requirements
- R1: While `rst_n` is low, and after its release, the pointer is 0, `busy` is 0, every bank register is 0 and all four pulse outputs are 0.
- R2: When `ptr_we` is high at a clock edge, the pointer takes `ptr_wdata`. This takes priority over any increment in the same cycle.
- R3: When `win_we` is high at a clock edge, `win_wdata` is stored into the register the pointer selects.
- R4: `win_rdata` always shows the contents of the register the pointer currently selects, in the same cycle and without a clock.
- R5: In a cycle with `win_we` or `win_re` high (or both) and `ptr_we` low, the pointer increases by exactly one at the next edge and wraps from 15 to 0.
- R6: Opcode encoding is 00 for reset, 01 for equalize, 10 for decode and 11 for traceback. An accepted opcode write raises the matching pulse output for exactly the one cycle after the write. At most one pulse output is high at any time.
- R7: `busy` rises in the cycle after an accepted non-reset opcode write. It falls in the cycle after `eng_done` is seen high while `busy` is high. `eng_done` has no effect while `busy` is low.
- R8: An opcode write made while `busy` is high is ignored. It produces no pulse, `busy` does not change, and a reset opcode clears nothing.
- R9: An accepted reset opcode clears registers 0 and 1 at the next edge and wins over a same-cycle window write to either of them. It leaves the other registers unchanged and leaves `busy` low.
- R10: `ctrl_word` and `tb_len` always show registers 0 and 1. `metric_sel` always shows bit 0 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_we | input | 1 | Load the pointer |
| ptr_wdata | input | 4 | New pointer value |
| win_we | input | 1 | Write through the data window |
| win_re | input | 1 | Read through the data window (advances the pointer) |
| win_wdata | input | 16 | Data to write |
| win_rdata | output | 16 | Contents of the selected register |
| ptr | output | 4 | Current pointer value |
| op_we | input | 1 | Opcode write strobe |
| op_code | input | 2 | Opcode: 00 reset, 01 equalize, 10 decode, 11 traceback |
| eng_done | input | 1 | Engine has finished the running operation |
| busy | output | 1 | An operation is running |
| go_eq | output | 1 | Start pulse for equalization |
| go_dec | output | 1 | Start pulse for convolutional decoding |
| go_tb | output | 1 | Start pulse for traceback only |
| go_rst | output | 1 | Engine reset pulse |
| ctrl_word | output | 16 | Register 0, the mode control word |
| tb_len | output | 16 | Register 1, the traceback length |
| metric_sel | output | 1 | Branch metric select, bit 0 of register 0 |

## Verification
The bound checker checks on every cycle the relations that span one clock edge. These are the pointer load and increment, the one-hot pulse outputs, busy rising and falling, opcodes being ignored while busy, and the reset opcode clearing the control and length registers. Other behaviour needs sequences that only the bench scenarios create. This covers data landing in the right register and reading back later, the pointer wrapping through a long stream of accesses, a reset opcode sparing the other registers, and a reset opcode winning a same-cycle collision with a window write. The bench shadows the bank in a model and compares against it under random traffic and directed corner cases.

// File: rtl/copro_regport.sv
module copro_regport #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          win_we,
  input  logic          win_re,
  input  logic [DW-1:0] win_wdata,
  output logic [DW-1:0] win_rdata,
  output logic [AW-1:0] ptr,
  input  logic          op_we,
  input  logic [1:0]    op_code,
  input  logic          eng_done,
  output logic          busy,
  output logic          go_eq,
  output logic          go_dec,
  output logic          go_tb,
  output logic          go_rst,
  output logic [DW-1:0] ctrl_word,
  output logic [DW-1:0] tb_len,
  output logic          metric_sel
);
  localparam int DEPTH = 1 << AW;
  localparam int CTRL_IDX = 0;
  localparam int TBL_IDX = 1;
  localparam logic [1:0] OP_RST = 2'b00;
  localparam logic [1:0] OP_EQ  = 2'b01;
  localparam logic [1:0] OP_DEC = 2'b10;
  localparam logic [1:0] OP_TB  = 2'b11;

  logic [DW-1:0] bank [DEPTH];
  logic [AW-1:0] ptr_q;
  logic          busy_q;
  logic [3:0]    go_q;

  wire access = win_we | win_re;
  wire op_take = op_we & ~busy_q;
  wire op_clear = op_take & (op_code == OP_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_we) ptr_q <= ptr_wdata;
    else if (access) ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (op_clear && (i == CTRL_IDX || i == TBL_IDX)) bank[i] <= '0;
        else if (win_we && ptr_q == AW'(i)) bank[i] <= win_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      go_q   <= '0;
    end else begin
      go_q <= '0;
      if (op_take) begin
        go_q[0] <= op_code == OP_EQ;
        go_q[1] <= op_code == OP_DEC;
        go_q[2] <= op_code == OP_TB;
        go_q[3] <= op_code == OP_RST;
      end
      if (busy_q) busy_q <= ~eng_done;
      else busy_q <= op_take & (op_code != OP_RST);
    end
  end

  assign win_rdata  = bank[ptr_q];
  assign ptr        = ptr_q;
  assign busy       = busy_q;
  assign go_eq      = go_q[0];
  assign go_dec     = go_q[1];
  assign go_tb      = go_q[2];
  assign go_rst     = go_q[3];
  assign ctrl_word  = bank[CTRL_IDX];
  assign tb_len     = bank[TBL_IDX];
  assign metric_sel = bank[CTRL_IDX][0];
endmodule

// File: rtl/copro_regport_chk.sv
module copro_regport_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_we,
  input logic [AW-1:0] ptr_wdata,
  input logic          win_we,
  input logic          win_re,
  input logic [AW-1:0] ptr,
  input logic          op_we,
  input logic [1:0]    op_code,
  input logic          eng_done,
  input logic          busy,
  input logic          go_eq,
  input logic          go_dec,
  input logic          go_tb,
  input logic          go_rst,
  input logic [DW-1:0] ctrl_word,
  input logic [DW-1:0] tb_len
);
  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> ptr == $past(ptr_wdata));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && (win_we || win_re)) |=> ptr == AW'($past(ptr) + 1'b1));

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && !win_we && !win_re) |=> $stable(ptr));

  assert_go_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_eq, go_dec, go_tb, go_rst}));

  assert_go_eq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && !busy && op_code == 2'b01) |=> go_eq && busy);

  assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> !busy);

  assert_idle_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !op_we) |=> !busy);

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !go_eq && !go_dec && !go_tb && !go_rst);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> busy);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && !busy && op_code == 2'b00) |=> ctrl_word == '0 && tb_len == '0 && go_rst && !busy);
endmodule

bind copro_regport copro_regport_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
  .win_we(win_we), .win_re(win_re), .ptr(ptr), .op_we(op_we),
  .op_code(op_code), .eng_done(eng_done), .busy(busy), .go_eq(go_eq),
  .go_dec(go_dec), .go_tb(go_tb), .go_rst(go_rst),
  .ctrl_word(ctrl_word), .tb_len(tb_len)
);

// File: tb/copro_regport_tb.sv
module copro_regport_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_we = 1'b0;
  logic [3:0]  ptr_wdata = '0;
  logic        win_we = 1'b0;
  logic        win_re = 1'b0;
  logic [15:0] win_wdata = '0;
  logic [15:0] win_rdata;
  logic [3:0]  ptr;
  logic        op_we = 1'b0;
  logic [1:0]  op_code = '0;
  logic        eng_done = 1'b0;
  logic        busy, go_eq, go_dec, go_tb, go_rst, metric_sel;
  logic [15:0] ctrl_word, tb_len;

  int checks = 0;
  int fails = 0;
  logic [15:0] m_bank [16];
  logic [3:0]  m_ptr;
  logic        m_busy;
  logic [3:0]  m_go;

  always #5 clk = ~clk;

  copro_regport u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .win_we(win_we), .win_re(win_re), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .ptr(ptr), .op_we(op_we), .op_code(op_code), .eng_done(eng_done),
    .busy(busy), .go_eq(go_eq), .go_dec(go_dec), .go_tb(go_tb), .go_rst(go_rst),
    .ctrl_word(ctrl_word), .tb_len(tb_len), .metric_sel(metric_sel)
  );

  function automatic logic [3:0] exp_go(input logic we, input logic bsy, input logic [1:0] oc);
    if (!we || bsy) return 4'b0000;
    case (oc)
      2'b01: return 4'b0001;
      2'b10: return 4'b0010;
      2'b11: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic [3:0] exp_ptr(input logic ld, input logic [3:0] nv, input logic acc, input logic [3:0] cur);
    if (ld) return nv;
    if (acc) return cur + 4'd1;
    return cur;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    logic [3:0] np;
    chk("R4 read", 32'(win_rdata), 32'(m_bank[m_ptr]));
    np = exp_ptr(ptr_we, ptr_wdata, win_we | win_re, m_ptr);
    if (win_we) m_bank[m_ptr] = win_wdata;
    if (op_we && !m_busy && op_code == 2'b00) begin
      m_bank[0] = '0;
      m_bank[1] = '0;
    end
    m_go = exp_go(op_we, m_busy, op_code);
    m_busy = m_busy ? !eng_done : (op_we && !m_busy && op_code != 2'b00);
    m_ptr = np;
    @(posedge clk);
    @(negedge clk);
    ptr_we = 0; win_we = 0; win_re = 0; op_we = 0; eng_done = 0;
    chk("R2/R5 pointer", 32'(ptr), 32'(m_ptr));
    chk("R7/R8 busy", 32'(busy), 32'(m_busy));
    chk("R6 pulses", 32'({go_rst, go_tb, go_dec, go_eq}), 32'(m_go));
    chk("R10 ctrl", 32'(ctrl_word), 32'(m_bank[0]));
    chk("R10 tblen", 32'(tb_len), 32'(m_bank[1]));
    chk("R10 metric", 32'(metric_sel), 32'(m_bank[0][0]));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int seed;
    logic [3:0] keep;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) m_bank[i] = '0;
    m_ptr = '0; m_busy = 0; m_go = '0;
    #23;
    chk("R1 reset ptr", 32'(ptr), 0);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset pulses", 32'({go_rst, go_tb, go_dec, go_eq}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset bank", 32'(win_rdata), 0);

    // R2/R3/R5: stream writes over all 16 plus wrap
    ptr_we = 1; ptr_wdata = 4'd14; cycle();
    for (int i = 0; i < 18; i++) begin
      win_we = 1; win_wdata = 16'h1000 + 16'(i); cycle();
    end
    chk("R5 wrap", 32'(ptr), 32'(4'd0));
    // R4/R5: read stream
    for (int i = 0; i < 16; i++) begin win_re = 1; cycle(); end
    // R2 priority over increment
    ptr_we = 1; ptr_wdata = 4'd7; win_re = 1; cycle();
    chk("R2 priority", 32'(ptr), 7);
    // R9 collision and sparing of other regs
    ptr_we = 1; ptr_wdata = 4'd0; cycle();
    keep = 4'd0;
    win_we = 1; win_wdata = 16'hbeef; op_we = 1; op_code = 2'b00; cycle();
    chk("R9 clear ctrl", 32'(ctrl_word), 0);
    ptr_we = 1; ptr_wdata = 4'd5; cycle();
    chk("R9 spare reg5", 32'(win_rdata), 32'(16'h1007));
    // R10 metric select
    ptr_we = 1; ptr_wdata = keep; cycle();
    win_we = 1; win_wdata = 16'h0003; cycle();
    chk("R10 metric bit", 32'(metric_sel), 1);
    // R6/R7/R8 directed
    op_we = 1; op_code = 2'b10; cycle();
    op_we = 1; op_code = 2'b00; cycle();
    chk("R8 reset ignored while busy", 32'(ctrl_word), 3);
    op_we = 1; op_code = 2'b11; cycle();
    eng_done = 1; cycle();
    chk("R7 busy fell", 32'(busy), 0);
    eng_done = 1; cycle();
    op_we = 1; op_code = 2'b11; cycle();
    eng_done = 1; cycle();
    op_we = 1; op_code = 2'b01; cycle();
    eng_done = 1; cycle();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      ptr_we = ($urandom % 8) == 0;
      ptr_wdata = 4'($urandom);
      win_we = ($urandom % 3) == 0;
      win_re = ($urandom % 3) == 0;
      win_wdata = 16'($urandom);
      op_we = ($urandom % 6) == 0;
      op_code = 2'($urandom);
      eng_done = ($urandom % 5) == 0;
      cycle();
    end
    summary();
  end
endmodule